// File: doc/BRIEF.md
# Double-Buffered 10-bit PWM Generator

This block produces one pulse-width-modulated output from an 8-bit period timer. The timer advances on an instruction-rate tick, which is one tick every four clocks, divided further by a selectable prescaler. Two fine bits taken from the prescaler chain extend the 8-bit timer to a 10-bit position. Comparing a 10-bit duty value against that position gives 10-bit pulse resolution from an 8-bit timer.

Software sets the period, the prescale ratio and the duty value through a small register write port. The duty value is written as an 8-bit upper part and a 2-bit lower part, and either part may be written at any moment. The block keeps a shadow copy of the duty value and loads it only at the start of a period, so a write in the middle of a period never shortens or lengthens the pulse that is in progress. The shadow is visible on a read-back port. A one-cycle strobe marks the first clock of every period.

The write port uses a valid/ready handshake. `wr_ready` is always high, so the port never applies back-pressure, and a beat is taken on every clock edge where `wr_valid` is high. The enable and the outputs are plain level signals.

Top module: `pwm10_dbuf`

## Requirements
- R1: After reset `pwm_out`, `period_strobe` and `shadow_duty` are all 0.
- R2: `wr_ready` is always 1. A beat with `wr_valid` high is stored on that clock edge. Address 0 writes the upper 8 duty bits. Address 1 writes the lower 2 duty bits from `wr_data[1:0]`. Address 2 writes the 8-bit period value PR. Address 3 writes the prescale code from `wr_data[1:0]`.
- R3: A period lasts (PR+1)*4*P clocks. `period_strobe` is high for exactly the first clock of each period.
- R4: Prescale code 00 gives P=1, code 01 gives P=4, and codes 10 and 11 give P=16.
- R5: For a loaded duty D, `pwm_out` is high for the first D*P clocks of the period and low for the rest. It rises only in the first clock of a period.
- R6: With D=0, `pwm_out` stays low for the whole period.
- R7: When D*P is at least the period length, `pwm_out` stays high for the whole period.
- R8: Duty writes change neither `pwm_out` nor `shadow_duty` during the current period. The new value is shown on `shadow_duty` from the first clock of the next period and is used for that whole period.
- R9: While `en` is low, `pwm_out` and `period_strobe` are low and the timer is held. The first clock after `en` is sampled high is the first clock of a period, and the shadow is loaded then.
- R10: The loaded duty is {upper part, lower part}, so the lower 2 bits adjust the pulse in steps of P clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable for timer and output |
| wr_valid | input | 1 | Write beat valid |
| wr_ready | output | 1 | Write beat accepted (always 1) |
| wr_addr | input | 2 | Register select |
| wr_data | input | 8 | Write data |
| pwm_out | output | 1 | PWM output level |
| period_strobe | output | 1 | High in the first clock of each period |
| shadow_duty | output | 10 | Duty value in use for the current period |

## Verification
All three outputs are registered, and they are updated on the same edge that moves the timer to a new position. So the state for period position p, counted from 0 at the strobe, is visible one step after the edge that starts position p. The bench waits for each rising edge, waits a short delay after it, and then compares `pwm_out` with p < D*P, the strobe with p = 0, and the shadow with the duty loaded at the last period start. Duty writes are placed in positions 0 and 1 and are captured at the edges that follow, so every write completes before the period ends and the new value is due exactly at the next position 0.

// File: rtl/pwm10_pkg.sv
package pwm10_pkg;

  typedef enum logic [1:0] {
    PS_DIV1   = 2'b00,
    PS_DIV4   = 2'b01,
    PS_DIV16  = 2'b10,
    PS_DIV16B = 2'b11
  } ps_sel_e;

  localparam logic [1:0] ADR_DUTY_HI = 2'd0;
  localparam logic [1:0] ADR_DUTY_LO = 2'd1;
  localparam logic [1:0] ADR_PERIOD  = 2'd2;
  localparam logic [1:0] ADR_PSCALE  = 2'd3;

  // log2 of the prescale ratio
  function automatic int unsigned ps_shift(ps_sel_e s);
    case (s)
      PS_DIV1: return 0;
      PS_DIV4: return 2;
      default: return 4;
    endcase
  endfunction

endpackage

// File: rtl/pwm10_regs.sv
module pwm10_regs
  import pwm10_pkg::*;
#(
  parameter int TMR_W  = 8,
  parameter int FINE_W = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_valid,
  output logic                      wr_ready,
  input  logic [1:0]                wr_addr,
  input  logic [TMR_W-1:0]          wr_data,
  output logic [TMR_W+FINE_W-1:0]   duty_buf,
  output logic [TMR_W-1:0]          period,
  output ps_sel_e                   ps_sel
);

  logic [TMR_W-1:0]  duty_hi_q;
  logic [FINE_W-1:0] duty_lo_q;
  logic              take;

  assign wr_ready = 1'b1;
  assign take     = wr_valid && wr_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      duty_hi_q <= '0;
      duty_lo_q <= '0;
      period    <= '1;
      ps_sel    <= PS_DIV1;
    end else if (take) begin
      case (wr_addr)
        ADR_DUTY_HI: duty_hi_q <= wr_data;
        ADR_DUTY_LO: duty_lo_q <= wr_data[FINE_W-1:0];
        ADR_PERIOD:  period    <= wr_data;
        default:     ps_sel    <= ps_sel_e'(wr_data[1:0]);
      endcase
    end
  end

  assign duty_buf = {duty_hi_q, duty_lo_q};

endmodule

// File: rtl/pwm10_timebase.sv
module pwm10_timebase
  import pwm10_pkg::*;
#(
  parameter int TMR_W      = 8,
  parameter int FINE_W     = 2,
  parameter int PS_LOG_MAX = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic [TMR_W-1:0]        period,
  input  ps_sel_e                 ps_sel,
  output logic                    start_o,
  output logic [TMR_W+FINE_W-1:0] pos_nxt
);

  localparam int PRE_W = FINE_W + PS_LOG_MAX;

  logic [TMR_W-1:0]  tmr_q, tmr_nxt;
  logic [PRE_W-1:0]  pre_q, pre_nxt, pre_last;
  logic              armed_q;
  logic              pre_done, match;
  logic [FINE_W-1:0] fine_nxt;
  int unsigned       sh;

  always_comb begin
    sh       = ps_shift(ps_sel);
    pre_last = PRE_W'((1 << (FINE_W + sh)) - 1);
  end

  assign pre_done = (pre_q >= pre_last);
  assign match    = pre_done && (tmr_q == period);
  assign start_o  = en && (armed_q || match);

  always_comb begin
    if (start_o) begin
      tmr_nxt = '0;
      pre_nxt = '0;
    end else if (pre_done) begin
      tmr_nxt = tmr_q + 1'b1;
      pre_nxt = '0;
    end else begin
      tmr_nxt = tmr_q;
      pre_nxt = pre_q + 1'b1;
    end
  end

  assign fine_nxt = FINE_W'(pre_nxt >> sh);
  assign pos_nxt  = {tmr_nxt, fine_nxt};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q   <= '0;
      pre_q   <= '0;
      armed_q <= 1'b1;
    end else if (!en) begin
      tmr_q   <= '0;
      pre_q   <= '0;
      armed_q <= 1'b1;
    end else begin
      tmr_q   <= tmr_nxt;
      pre_q   <= pre_nxt;
      armed_q <= 1'b0;
    end
  end

  AST_START_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |=> (tmr_q == '0 && pre_q == '0)) else $error("start"); // R3

  AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (tmr_q == '0 && pre_q == '0)) else $error("hold"); // R9

endmodule

// File: rtl/pwm10_compare.sv
module pwm10_compare #(
  parameter int DUTY_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              start_i,
  input  logic [DUTY_W-1:0] pos_nxt,
  input  logic [DUTY_W-1:0] duty_buf,
  output logic              pwm_q,
  output logic              strobe_q,
  output logic [DUTY_W-1:0] shadow_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwm_q    <= 1'b0;
      strobe_q <= 1'b0;
      shadow_q <= '0;
    end else if (!en) begin
      pwm_q    <= 1'b0;
      strobe_q <= 1'b0;
    end else if (start_i) begin
      shadow_q <= duty_buf;
      pwm_q    <= (duty_buf != '0);
      strobe_q <= 1'b1;
    end else begin
      strobe_q <= 1'b0;
      if (pos_nxt == shadow_q) pwm_q <= 1'b0;
    end
  end

  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> $stable(shadow_q)) else $error("shadow"); // R8

  AST_RISE_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwm_q) |-> strobe_q) else $error("rise"); // R5

endmodule

// File: rtl/pwm10_dbuf.sv
module pwm10_dbuf
  import pwm10_pkg::*;
#(
  parameter int TMR_W      = 8,
  parameter int FINE_W     = 2,
  parameter int PS_LOG_MAX = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic                    wr_valid,
  output logic                    wr_ready,
  input  logic [1:0]              wr_addr,
  input  logic [TMR_W-1:0]        wr_data,
  output logic                    pwm_out,
  output logic                    period_strobe,
  output logic [TMR_W+FINE_W-1:0] shadow_duty
);

  localparam int DUTY_W = TMR_W + FINE_W;

  logic [DUTY_W-1:0] duty_buf;
  logic [TMR_W-1:0]  period;
  ps_sel_e           ps_sel;
  logic              start;
  logic [DUTY_W-1:0] pos_nxt;

  pwm10_regs #(.TMR_W(TMR_W), .FINE_W(FINE_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .duty_buf(duty_buf),
    .period(period), .ps_sel(ps_sel)
  );

  pwm10_timebase #(.TMR_W(TMR_W), .FINE_W(FINE_W), .PS_LOG_MAX(PS_LOG_MAX)) u_tb (
    .clk(clk), .rst_n(rst_n), .en(en), .period(period), .ps_sel(ps_sel),
    .start_o(start), .pos_nxt(pos_nxt)
  );

  pwm10_compare #(.DUTY_W(DUTY_W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .en(en), .start_i(start), .pos_nxt(pos_nxt),
    .duty_buf(duty_buf), .pwm_q(pwm_out), .strobe_q(period_strobe),
    .shadow_q(shadow_duty)
  );

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    period_strobe |=> !period_strobe) else $error("strobe"); // R3

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!pwm_out && !period_strobe)) else $error("idle"); // R9

  AST_ZERO_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (period_strobe && shadow_duty == '0) |-> !pwm_out) else $error("zero"); // R6

  AST_READY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> wr_ready) else $error("ready"); // R2

endmodule

// File: tb/sim_pwm10_dbuf.sv
`timescale 1ns/1ps
module sim_pwm10_dbuf;

  logic       clk = 1'b0;
  logic       rst_n, en, wr_valid, wr_ready;
  logic [1:0] wr_addr;
  logic [7:0] wr_data;
  logic       pwm_out, period_strobe;
  logic [9:0] shadow_duty;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  pwm10_dbuf u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .pwm_out(pwm_out),
    .period_strobe(period_strobe), .shadow_duty(shadow_duty)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // one register beat, issued just after an edge
  task automatic put(input logic [1:0] a, input logic [7:0] d);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    chk(wr_ready === 1'b1, "R2 ready", int'(wr_ready), 1);
    wr_valid = 1'b0;
  endtask

  // check one whole period with loaded duty d; stage nd for the next one
  task automatic run_period(input int d, input int nd, input int len, input int p);
    string tag;
    for (int pos = 0; pos < len; pos++) begin
      @(posedge clk); #1;
      if (d == 0)           tag = "R6 zero duty";
      else if (d * p >= len) tag = "R7 duty over period";
      else                  tag = "R5 R4 high time";
      chk(pwm_out === (pos < d * p), tag, int'(pwm_out), int'(pos < d * p));
      chk(period_strobe === (pos == 0), "R3 strobe", int'(period_strobe), int'(pos == 0));
      if (pos == 0)
        chk(shadow_duty == 10'(d), "R8 R10 shadow load", int'(shadow_duty), d);
      if (pos == len - 1)
        chk(shadow_duty == 10'(d), "R8 shadow held", int'(shadow_duty), d);
      if (pos == 0) begin
        wr_valid = 1'b1; wr_addr = 2'd0; wr_data = 8'(nd >> 2);
      end else if (pos == 1) begin
        chk(wr_ready === 1'b1, "R2 ready", int'(wr_ready), 1);
        wr_addr = 2'd1; wr_data = 8'(nd & 3);
      end else if (pos == 2) begin
        wr_valid = 1'b0;
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int prs[4];
    prs[0] = 0; prs[1] = 1; prs[2] = 3; prs[3] = 5;
    rst_n = 1'b0; en = 1'b0; wr_valid = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (3) @(posedge clk);
    #1;
    chk(pwm_out === 1'b0, "R1 pwm", int'(pwm_out), 0);
    chk(period_strobe === 1'b0, "R1 strobe", int'(period_strobe), 0);
    chk(shadow_duty === 10'd0, "R1 shadow", int'(shadow_duty), 0);
    rst_n = 1'b1;
    @(posedge clk); #1;

    foreach (prs[k]) begin
      for (int ps = 0; ps < 4; ps++) begin
        int p, len, nd_cnt;
        int duties[$];
        p   = (ps == 0) ? 1 : (ps == 1) ? 4 : 16;
        len = (prs[k] + 1) * 4 * p;
        nd_cnt = (prs[k] + 1) * 4 + 2;
        duties = {};
        for (int d = 0; d < nd_cnt; d++) duties.push_back(d);
        duties.push_back(1023);
        duties.push_back(0);
        put(2'd2, 8'(prs[k]));
        put(2'd3, 8'(ps));
        put(2'd0, 8'(duties[0] >> 2));
        put(2'd1, 8'(duties[0] & 3));
        // R9: idle while disabled
        chk(pwm_out === 1'b0, "R9 idle pwm", int'(pwm_out), 0);
        chk(period_strobe === 1'b0, "R9 idle strobe", int'(period_strobe), 0);
        en = 1'b1;
        for (int i = 0; i < duties.size() - 1; i++)
          run_period(duties[i], duties[i + 1], len, p);
        en = 1'b0;
        for (int c = 0; c < 3; c++) begin
          @(posedge clk); #1;
          chk(pwm_out === 1'b0, "R9 off pwm", int'(pwm_out), 0);
          chk(period_strobe === 1'b0, "R9 off strobe", int'(period_strobe), 0);
        end
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule